// File: doc/BRIEF.md
# Scanline and Frame Timing Generator

This block turns a free-running system clock into raster timing events. It divides the clock into scanlines. The length of each scanline comes from a fixed-point cycles-per-line accumulator with 12 fractional bits. Each line, the accumulator takes the integer part of the running sum as that line's length in clock cycles and keeps only the fraction for the next line. Over many lines, the average line period therefore matches a non-integer ratio.

Two television standards are supported. One is a 60 Hz standard with 263 lines per frame and vertical blank starting at line 240. The other is a 50 Hz standard with 313 lines per frame and vertical blank starting at line 256. A plain select input chooses between them. The block samples that input only on the last cycle of a frame, so a frame never mixes the two standards. The outputs are four single-cycle event pulses: end of line, start of vertical blank, end of frame (used as the frame interrupt) and an audio-update strobe every 32 lines. The block also drives the current line number and the standard in use. All of these are plain control pins. There is no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `line_timing_gen`

## Requirements
- R1: While reset is asserted and on the first cycle after release, line_index is 0, std_active is 0 (60 Hz) and all four pulses are low. The first line uses the 60 Hz increment.
- R2: Each line lasts `(frac + inc) >> 12` clock cycles. Here `frac` is the 12-bit remainder carried over from the previous line (initially the low 12 bits of the 60 Hz increment) and `inc` is 8791293 for 60 Hz or 8864320 for 50 Hz. Only the low 12 bits of the sum are carried on.
- R3: line_tick is high for exactly one cycle, the last clock cycle of every line.
- R4: line_index counts lines from 0 and advances by one at each line end. After line total−1 it returns to 0. The total is 263 lines for 60 Hz and 313 lines for 50 Hz.
- R5: frame_end pulses on the last cycle of line total−1, the same cycle in which line_index wraps to 0.
- R6: vblank_start pulses at the end of the line on which line_index advances to the vblank line: 240 for 60 Hz, 256 for 50 Hz. It never coincides with frame_end.
- R7: audio_upd pulses at the end of every 32nd line after reset. It counts lines continuously, independent of frame boundaries, and then restarts its count.
- R8: std_sel (0 = 60 Hz, 1 = 50 Hz) is sampled only in a frame_end cycle. The sampled value sets std_active, the frame totals and the increment from the following cycle onward. A change of std_sel at any other time has no effect on any output.
- R9: Every event pulse (vblank_start, frame_end, audio_upd) coincides with line_tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| std_sel | input | 1 | Requested standard: 0 = 60 Hz / 263 lines, 1 = 50 Hz / 313 lines |
| line_tick | output | 1 | Pulse on the last cycle of each line |
| vblank_start | output | 1 | Pulse at the end of the line before vertical blank |
| frame_end | output | 1 | Frame interrupt pulse on the last cycle of a frame |
| audio_upd | output | 1 | Pulse every AUDIO_LINES lines |
| line_index | output | LINE_W (9) | Current line number within the frame |
| std_active | output | 1 | Standard in use for the current frame |

## Verification
The hardest situation to reach from the ports is a standard change that lands exactly on the frame_end cycle. The same applies to a brief glitch on std_sel in mid-frame. Both must be told apart from changes that take effect only one frame later. At full size a frame is over half a million cycles long, so the bench builds the block with small line counts and small increments. It keeps a non-zero fraction, so carries still occur. Many frames then fit into a short run. The bench toggles std_sel at fixed cycles, as a short mid-frame glitch, and exactly in cycles where its reference model predicts frame_end. It compares every output on every clock against that model.

// File: rtl/lt_pkg.sv
package lt_pkg;

  typedef enum logic {
    STD_60 = 1'b0,
    STD_50 = 1'b1
  } std_e;

endpackage

// File: rtl/lt_line_phase.sv
module lt_line_phase #(
  parameter int unsigned FRAC_BITS = 12,
  parameter int unsigned INC_W     = 24,
  parameter int unsigned RST_INC   = 8791293,
  localparam int unsigned LEN_W    = INC_W - FRAC_BITS + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [INC_W-1:0] inc_i,
  output logic             line_end_o,
  output logic [LEN_W-1:0] len_o
);

  localparam logic [INC_W:0] RST_SUM = (INC_W+1)'(RST_INC);

  logic [LEN_W-1:0]     cyc_q;
  logic [LEN_W-1:0]     len_q;
  logic [FRAC_BITS-1:0] frac_q;
  logic [INC_W:0]       sum;

  assign sum        = {{(INC_W+1-FRAC_BITS){1'b0}}, frac_q} + {1'b0, inc_i};
  assign line_end_o = (cyc_q == len_q - LEN_W'(1));
  assign len_o      = len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q  <= '0;
      len_q  <= RST_SUM[INC_W:FRAC_BITS];
      frac_q <= RST_SUM[FRAC_BITS-1:0];
    end else if (line_end_o) begin
      cyc_q  <= '0;
      len_q  <= sum[INC_W:FRAC_BITS];
      frac_q <= sum[FRAC_BITS-1:0];
    end else begin
      cyc_q  <= cyc_q + LEN_W'(1);
    end
  end

  // line length stays usable and the position never passes it
  assert_cyc_in_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (len_q != '0) && (cyc_q < len_q))
    else $error("cycle position outside line");

  assert_restart_after_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    line_end_o |=> (cyc_q == '0) && !line_end_o)
    else $error("line did not restart");

endmodule

// File: rtl/lt_line_seq.sv
module lt_line_seq #(
  parameter int unsigned LINE_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_end_i,
  input  logic [LINE_W-1:0] total_i,
  input  logic [LINE_W-1:0] vb_line_i,
  output logic [LINE_W-1:0] line_o,
  output logic              frame_end_o,
  output logic              vblank_o
);

  logic [LINE_W-1:0] line_q;
  logic [LINE_W-1:0] line_nxt;

  assign line_nxt    = line_q + LINE_W'(1);
  assign frame_end_o = line_end_i && (line_nxt == total_i);
  assign vblank_o    = line_end_i && (line_nxt == vb_line_i);
  assign line_o      = line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           line_q <= '0;
    else if (frame_end_o) line_q <= '0;
    else if (line_end_i)  line_q <= line_nxt;
  end

  assert_line_below_total_R4: assert property (@(posedge clk) disable iff (!rst_n)
    line_q < total_i)
    else $error("line index beyond frame total");

  assert_frame_wraps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end_o |=> (line_q == '0))
    else $error("frame end did not wrap");

  assert_line_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end_i |=> $stable(line_q))
    else $error("line index moved mid-line");

endmodule

// File: rtl/lt_audio_div.sv
module lt_audio_div #(
  parameter int unsigned AUDIO_LINES = 32,
  localparam int unsigned AW = $clog2(AUDIO_LINES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_end_i,
  output logic strobe_o
);

  localparam logic [AW-1:0] LAST = AW'(AUDIO_LINES - 1);

  logic [AW-1:0] cnt_q;

  assign strobe_o = line_end_i && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (strobe_o)   cnt_q <= '0;
    else if (line_end_i) cnt_q <= cnt_q + AW'(1);
  end

  assert_audio_on_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |-> line_end_i)
    else $error("audio strobe off line boundary");

  assert_audio_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |=> (cnt_q == '0))
    else $error("audio count not restarted");

endmodule

// File: rtl/line_timing_gen.sv
module line_timing_gen #(
  parameter int unsigned FRAC_BITS   = 12,
  parameter int unsigned INC_W       = 24,
  parameter int unsigned INC_60      = 8791293,
  parameter int unsigned INC_50      = 8864320,
  parameter int unsigned LINES_60    = 263,
  parameter int unsigned LINES_50    = 313,
  parameter int unsigned VB_60       = 240,
  parameter int unsigned VB_50       = 256,
  parameter int unsigned AUDIO_LINES = 32,
  localparam int unsigned MAX_LINES  = (LINES_60 > LINES_50) ? LINES_60 : LINES_50,
  localparam int unsigned LINE_W     = $clog2(MAX_LINES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              std_sel,
  output logic              line_tick,
  output logic              vblank_start,
  output logic              frame_end,
  output logic              audio_upd,
  output logic [LINE_W-1:0] line_index,
  output logic              std_active
);
  import lt_pkg::*;

  localparam int unsigned LEN_W = INC_W - FRAC_BITS + 1;

  std_e              std_q;
  std_e              std_nxt;
  logic [INC_W-1:0]  inc;
  logic [LINE_W-1:0] total;
  logic [LINE_W-1:0] vb_line;
  logic              line_end;
  logic [LEN_W-1:0]  len_unused;

  // the increment for the next line follows the standard of the frame it belongs to
  assign std_nxt = frame_end ? std_e'(std_sel) : std_q;
  assign inc     = (std_nxt == STD_50) ? INC_W'(INC_50)     : INC_W'(INC_60);
  assign total   = (std_q == STD_50)   ? LINE_W'(LINES_50)  : LINE_W'(LINES_60);
  assign vb_line = (std_q == STD_50)   ? LINE_W'(VB_50)     : LINE_W'(VB_60);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) std_q <= STD_60;
    else        std_q <= std_nxt;
  end

  lt_line_phase #(
    .FRAC_BITS (FRAC_BITS),
    .INC_W     (INC_W),
    .RST_INC   (INC_60)
  ) u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .inc_i      (inc),
    .line_end_o (line_end),
    .len_o      (len_unused)
  );

  lt_line_seq #(
    .LINE_W (LINE_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_end_i  (line_end),
    .total_i     (total),
    .vb_line_i   (vb_line),
    .line_o      (line_index),
    .frame_end_o (frame_end),
    .vblank_o    (vblank_start)
  );

  lt_audio_div #(
    .AUDIO_LINES (AUDIO_LINES)
  ) u_audio (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_end_i (line_end),
    .strobe_o   (audio_upd)
  );

  assign line_tick  = line_end;
  assign std_active = std_q;

  assert_std_frame_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_end) |-> $stable(std_active))
    else $error("standard changed away from frame end");

  assert_events_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (vblank_start || frame_end || audio_upd) |-> line_tick)
    else $error("event pulse without line tick");

  assert_vblank_not_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(vblank_start && frame_end))
    else $error("vblank and frame end together");

  assert_tick_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    line_tick && (len_unused > LEN_W'(1)) |=> !line_tick)
    else $error("line tick longer than one cycle");

endmodule

// File: tb/line_timing_gen_test.sv
module line_timing_gen_test;

  localparam int PERIOD = 10;
  localparam int F      = 12;
  localparam int INC60  = 5 * 4096 + 1537;
  localparam int INC50  = 6 * 4096 + 3001;
  localparam int L60    = 7;
  localparam int L50    = 9;
  localparam int V60    = 5;
  localparam int V50    = 6;
  localparam int AUD    = 4;
  localparam int NCYC   = 900;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       std_sel = 1'b0;
  logic       line_tick, vblank_start, frame_end, audio_upd, std_active;
  logic [3:0] line_index;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  line_timing_gen #(
    .FRAC_BITS(F), .INC_W(24), .INC_60(INC60), .INC_50(INC50),
    .LINES_60(L60), .LINES_50(L50), .VB_60(V60), .VB_50(V50),
    .AUDIO_LINES(AUD)
  ) uut (
    .clk(clk), .rst_n(rst_n), .std_sel(std_sel),
    .line_tick(line_tick), .vblank_start(vblank_start), .frame_end(frame_end),
    .audio_upd(audio_upd), .line_index(line_index), .std_active(std_active)
  );

  // reference state
  int m_cyc, m_len, m_frac, m_line, m_aud, m_std;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int sum;
    int tot, vb;
    bit e_tick, e_fe, e_vb, e_au;
    m_cyc = 0; m_len = INC60 >> F; m_frac = INC60 & 4095;
    m_line = 0; m_aud = 0; m_std = 0;
    repeat (3) @(negedge clk);
    // R1: outputs while reset is held
    check("R1 reset line_index", int'(line_index), 0);
    check("R1 reset std_active", int'(std_active), 0);
    check("R1 reset pulses", int'({line_tick, vblank_start, frame_end, audio_upd}), 0);
    rst_n = 1'b1;
    for (int n = 0; n < NCYC; n++) begin
      tot = m_std ? L50 : L60;
      vb  = m_std ? V50 : V60;
      e_tick = (m_cyc == m_len - 1);
      e_fe   = e_tick && (m_line + 1 == tot);
      e_vb   = e_tick && (m_line + 1 == vb);
      e_au   = e_tick && (m_aud == AUD - 1);
      check("R2/R3 line_tick", int'(line_tick), int'(e_tick));
      check("R5 frame_end", int'(frame_end), int'(e_fe));
      check("R6 vblank_start", int'(vblank_start), int'(e_vb));
      check("R7 audio_upd", int'(audio_upd), int'(e_au));
      check("R4 line_index", int'(line_index), m_line);
      check("R8 std_active", int'(std_active), m_std);
      if (n == 0) check("R1 first cycle after reset", int'(line_index), 0);
      // standard select stimulus: mid-frame changes, a glitch, and flips on frame end
      if (n == 60)  std_sel = 1'b1;
      if (n == 230) std_sel = 1'b0;
      if (n == 233) std_sel = 1'b1;
      if (n == 450) std_sel = 1'b0;
      if (n >= 600 && e_fe) std_sel = ~std_sel;
      // advance model as the clock edge would
      if (e_tick) begin
        if (e_fe) begin
          m_line = 0;
          m_std  = int'(std_sel);
        end else begin
          m_line = m_line + 1;
        end
        m_aud = e_au ? 0 : m_aud + 1;
        sum    = m_frac + (m_std ? INC50 : INC60);
        m_len  = sum >> F;
        m_frac = sum & 4095;
        m_cyc  = 0;
      end else begin
        m_cyc = m_cyc + 1;
      end
      @(negedge clk);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule